// File: doc/BRIEF.md
# Burst Address Latch and Wait Generator

This block sits between a host bus and a flash array that supports synchronous burst reads. It owns the address path and the flow-control signal that tells the host when the data on the bus can be taken. When the address lock input is low, the address bus passes straight through. When the lock input goes high, the block holds the address. In a synchronous read, the lock-low clock edge starts a burst. A programmable initial latency then runs. After that, the burst address steps forward on every clock edge at which data was valid. Crossing an aligned 16-word boundary costs one extra stall cycle.

The wait output is driven only during a synchronous read with both enables active. At all other times its enable is low, so a board-level bus can treat the pin as released. Three configuration inputs shape the wait output. One sets the latency. One selects whether wait marks the invalid cycle itself or warns one cycle ahead of it. One sets the polarity.

Top module: `burst_addr_wait`

## Requirements
- R1: While `addr_lock` is low, `addr_out` equals `addr_in` in the same cycle, in every mode.
- R2: While `addr_lock` is high outside a synchronous read, `addr_out` holds the value `addr_in` had at the last rising `clk` edge with `addr_lock` low. The address must be stable across that edge.
- R3: In an asynchronous read (`sync_mode`=0) or a write cycle (`wr_cycle`=1), clock edges change neither `addr_out` nor `data_valid` (which stays 0).
- R4: A synchronous read is `rst_n`=1, `ce_n`=0, `sync_mode`=1 and `wr_cycle`=0. Each rising edge with `addr_lock` low captures `addr_in` and restarts the burst. Counting the last such edge as edge 1, `data_valid` first rises after edge L. L is `cfg_latency`, with values 0 and 1 treated as 2.
- R5: In a synchronous read with `addr_lock` high, each rising edge at which data is valid advances `addr_out` by one, wrapping modulo 2^AW.
- R6: An advance from an address whose low 4 bits are 1111 is followed by exactly one cycle with `data_valid`=0, and the address does not move during that cycle.
- R7: `wait_oe` is high only in a synchronous read with `oe_n`=0. `data_valid` is 0 whenever `wait_oe` is 0.
- R8: With `cfg_wait_early`=0 and `wait_oe`=1, wait is asserted exactly in the cycles where `data_valid` is 0.
- R9: With `cfg_wait_early`=1 and `wait_oe`=1, wait is asserted in a cycle exactly when the data would not be valid in the following cycle, given the inputs stay unchanged.
- R10: `cfg_wait_pol`=0 gives an active-low wait (asserted = 0). `cfg_wait_pol`=1 gives an active-high wait.
- R11: A low `rst_n` at once clears the burst state and the held address to 0, and forces `data_valid` and `wait_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| sync_mode | input | 1 | 1 selects synchronous burst reads |
| wr_cycle | input | 1 | 1 marks a write cycle |
| addr_lock | input | 1 | Low: latch transparent / burst start; high: hold |
| addr_in | input | AW | Address bus from host |
| cfg_latency | input | 3 | Initial latency in clocks (2..7) |
| cfg_wait_early | input | 1 | 1 makes wait warn one cycle ahead |
| cfg_wait_pol | input | 1 | Wait polarity, 0 = active low |
| addr_out | output | AW | Address presented to the array |
| wait_o | output | 1 | Wait level |
| wait_oe | output | 1 | Drive enable for the wait pin |
| data_valid | output | 1 | Data on the bus is valid this cycle |

## Verification
The hardest situation to reach is an early-warning wait at the moment a boundary stall begins. At that point the warning must rise while the current data is still valid, and the burst has to have walked up to an address ending in 1111 after the latency ran out. The directed stimulus starts bursts a few words below a boundary with both minimum and maximum latency, in both wait timings. A long random phase then holds `addr_lock` high for long stretches so that bursts repeatedly cross boundaries, while the enables and modes flip underneath them.

// File: rtl/bawg_pkg.sv
package bawg_pkg;
   localparam int LAT_W = 3;

   typedef struct packed {
      logic             started;
      logic [LAT_W-1:0] lat;
      logic             stall;
   } tmr_st_t;

   function automatic logic [LAT_W-1:0] eff_latency(input logic [LAT_W-1:0] req,
                                                     input int unsigned    lmin);
      if (int'(req) < lmin) return LAT_W'(lmin);
      return req;
   endfunction
endpackage

// File: rtl/bawg_addr_path.sv
module bawg_addr_path #(
   parameter int AW       = 24,
   parameter int BND_BITS = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          addr_lock,
   input  logic [AW-1:0] addr_in,
   input  logic          adv,
   output logic [AW-1:0] addr_out,
   output logic          at_bnd
);
   logic [AW-1:0] cur_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cur_q <= '0;
      else if (!addr_lock) cur_q <= addr_in;
      else if (adv)        cur_q <= cur_q + AW'(1);
   end

   assign addr_out = addr_lock ? cur_q : addr_in;
   assign at_bnd   = &cur_q[BND_BITS-1:0];
endmodule

// File: rtl/bawg_lat_timer.sv
module bawg_lat_timer
   import bawg_pkg::*;
#(
   parameter int LAT_MIN = 2,
   parameter bit BND_EN  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_rd,
   input  logic             addr_lock,
   input  logic [LAT_W-1:0] cfg_latency,
   input  logic             at_bnd,
   output logic             ready,
   output logic             ready_nxt
);
   tmr_st_t st_q, st_d;
   logic    stall_term;
   logic [LAT_W-1:0] lat_load;

   assign lat_load = eff_latency(cfg_latency, LAT_MIN) - LAT_W'(1);
   assign ready    = st_q.started && (st_q.lat == '0) && !st_q.stall;

   generate
      if (BND_EN) begin : g_bnd
         assign stall_term = ready && at_bnd;
      end else begin : g_nobnd
         assign stall_term = 1'b0;
      end
   endgenerate

   always_comb begin
      st_d = st_q;
      if (!sync_rd) begin
         st_d = '0;
      end else if (!addr_lock) begin
         st_d.started = 1'b1;
         st_d.lat     = lat_load;
         st_d.stall   = 1'b0;
      end else begin
         if (st_q.lat != '0) st_d.lat = st_q.lat - LAT_W'(1);
         st_d.stall = stall_term;
      end
   end

   assign ready_nxt = st_d.started && (st_d.lat == '0) && !st_d.stall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= st_d;
   end
endmodule

// File: rtl/bawg_wait_drv.sv
module bawg_wait_drv (
   input  logic sync_rd,
   input  logic oe_n,
   input  logic ready,
   input  logic ready_nxt,
   input  logic cfg_wait_early,
   input  logic cfg_wait_pol,
   output logic wait_o,
   output logic wait_oe,
   output logic data_valid
);
   logic asserted;

   assign wait_oe    = sync_rd && !oe_n;
   assign data_valid = wait_oe && ready;
   assign asserted   = cfg_wait_early ? !ready_nxt : !ready;
   assign wait_o     = cfg_wait_pol ? asserted : !asserted;
endmodule

// File: rtl/burst_addr_wait.sv
module burst_addr_wait
   import bawg_pkg::*;
#(
   parameter int AW       = 24,
   parameter int BND_BITS = 4,
   parameter int LAT_MIN  = 2,
   parameter bit BND_EN   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce_n,
   input  logic             oe_n,
   input  logic             sync_mode,
   input  logic             wr_cycle,
   input  logic             addr_lock,
   input  logic [AW-1:0]    addr_in,
   input  logic [LAT_W-1:0] cfg_latency,
   input  logic             cfg_wait_early,
   input  logic             cfg_wait_pol,
   output logic [AW-1:0]    addr_out,
   output logic             wait_o,
   output logic             wait_oe,
   output logic             data_valid
);
   generate
      if (AW <= BND_BITS) begin : g_bad_aw
         $error("burst_addr_wait: AW must exceed BND_BITS");
      end
      if (LAT_MIN < 1 || LAT_MIN > 7) begin : g_bad_lat
         $error("burst_addr_wait: LAT_MIN out of range");
      end
   endgenerate

   logic sync_rd, ready, ready_nxt, at_bnd, adv;

   assign sync_rd = rst_n && !ce_n && sync_mode && !wr_cycle;
   assign adv     = sync_rd && addr_lock && ready;

   bawg_addr_path #(.AW(AW), .BND_BITS(BND_BITS)) u_addr (
      .clk(clk), .rst_n(rst_n), .addr_lock(addr_lock), .addr_in(addr_in),
      .adv(adv), .addr_out(addr_out), .at_bnd(at_bnd)
   );

   bawg_lat_timer #(.LAT_MIN(LAT_MIN), .BND_EN(BND_EN)) u_tmr (
      .clk(clk), .rst_n(rst_n), .sync_rd(sync_rd), .addr_lock(addr_lock),
      .cfg_latency(cfg_latency), .at_bnd(at_bnd),
      .ready(ready), .ready_nxt(ready_nxt)
   );

   bawg_wait_drv u_wait (
      .sync_rd(sync_rd), .oe_n(oe_n), .ready(ready), .ready_nxt(ready_nxt),
      .cfg_wait_early(cfg_wait_early), .cfg_wait_pol(cfg_wait_pol),
      .wait_o(wait_o), .wait_oe(wait_oe), .data_valid(data_valid)
   );
endmodule

// File: rtl/bawg_chk.sv
module bawg_chk #(
   parameter int AW       = 24,
   parameter int BND_BITS = 4,
   parameter bit BND_EN   = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ce_n,
   input logic          oe_n,
   input logic          sync_mode,
   input logic          wr_cycle,
   input logic          addr_lock,
   input logic          cfg_wait_early,
   input logic          cfg_wait_pol,
   input logic [AW-1:0] addr_out,
   input logic          wait_o,
   input logic          wait_oe,
   input logic          data_valid
);
   logic srd;
   assign srd = rst_n && !ce_n && sync_mode && !wr_cycle;

   always_comb begin
      if (!rst_n || ce_n || oe_n) begin
         a_r7_released: assert (!wait_oe && !data_valid);
      end
   end

   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_lock && $past(addr_lock) && !$past(srd)) |-> $stable(addr_out));

   a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (srd && addr_lock && data_valid) ##1 addr_lock
      |-> addr_out == $past(addr_out) + AW'(1));

   a_r8_late_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_wait_early && wait_oe) |-> ((wait_o == cfg_wait_pol) == !data_valid));

   a_r9_early_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wait_early && wait_oe && wait_o != cfg_wait_pol) ##1
      ($stable({ce_n, oe_n, sync_mode, wr_cycle, cfg_wait_early}) &&
       addr_lock && $past(addr_lock))
      |-> data_valid);

   generate
      if (BND_EN) begin : g_bnd_chk
         a_r6_boundary_stall: assert property (@(posedge clk) disable iff (!rst_n)
            (srd && addr_lock && data_valid && (&addr_out[BND_BITS-1:0])) ##1
            (srd && addr_lock) |-> !data_valid);
      end
   endgenerate
endmodule

bind burst_addr_wait bawg_chk #(.AW(AW), .BND_BITS(BND_BITS), .BND_EN(BND_EN)) u_chk (
   .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .sync_mode(sync_mode),
   .wr_cycle(wr_cycle), .addr_lock(addr_lock), .cfg_wait_early(cfg_wait_early),
   .cfg_wait_pol(cfg_wait_pol), .addr_out(addr_out), .wait_o(wait_o),
   .wait_oe(wait_oe), .data_valid(data_valid)
);

// File: tb/burst_addr_wait_tb.sv
`timescale 1ns/1ps
module burst_addr_wait_tb;
   localparam int AW = 24;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n, ce_n, oe_n, sync_mode, wr_cycle, addr_lock;
   logic [AW-1:0] addr_in, addr_out;
   logic [2:0] cfg_latency;
   logic cfg_wait_early, cfg_wait_pol;
   logic wait_o, wait_oe, data_valid;

   burst_addr_wait #(.AW(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .sync_mode(sync_mode),
      .wr_cycle(wr_cycle), .addr_lock(addr_lock), .addr_in(addr_in),
      .cfg_latency(cfg_latency), .cfg_wait_early(cfg_wait_early),
      .cfg_wait_pol(cfg_wait_pol), .addr_out(addr_out), .wait_o(wait_o),
      .wait_oe(wait_oe), .data_valid(data_valid)
   );

   int vectors = 0, fails = 0;
   bit done = 0;

   // behavioural reference state
   logic [AW-1:0] m_cur;
   bit m_st, m_stall;
   int m_lat;

   task automatic chk(string tag, string what, longint act, longint exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic step(bit r, bit ce, bit oe, bit sm, bit wr, bit lk,
                       logic [AW-1:0] a, string tag);
      bit sync, rdy, n_st, n_stall, rdy_n, asrt;
      int n_lat, eff;
      logic [AW-1:0] n_cur;
      rst_n = r; ce_n = ce; oe_n = oe; sync_mode = sm; wr_cycle = wr;
      addr_lock = lk; addr_in = a;
      #1;
      if (!r) begin m_cur = '0; m_st = 0; m_stall = 0; m_lat = 0; end
      sync = r && !ce && sm && !wr;
      rdy  = m_st && m_lat == 0 && !m_stall;
      eff  = (cfg_latency < 2) ? 2 : int'(cfg_latency);
      if (!r) begin
         n_cur = '0; n_st = 0; n_lat = 0; n_stall = 0;
      end else begin
         n_cur = !lk ? a : ((sync && rdy) ? m_cur + 1'b1 : m_cur);
         if (!sync)    begin n_st = 0; n_lat = 0; n_stall = 0; end
         else if (!lk) begin n_st = 1; n_lat = eff - 1; n_stall = 0; end
         else begin
            n_st = m_st; n_lat = (m_lat > 0) ? m_lat - 1 : 0;
            n_stall = rdy && (m_cur[3:0] == 4'hF);
         end
      end
      rdy_n = n_st && n_lat == 0 && !n_stall;
      asrt  = cfg_wait_early ? !rdy_n : !rdy;
      chk(tag, "addr_out", addr_out, lk ? m_cur : a);
      chk(sync ? "R4" : "R3", "data_valid", data_valid, sync && !oe && rdy);
      chk(r ? "R7" : "R11", "wait_oe", wait_oe, sync && !oe);
      if (sync && !oe)
         chk(cfg_wait_early ? "R9" : "R8", "wait_o", wait_o, cfg_wait_pol ? asrt : !asrt);
      @(posedge clk);
      m_cur = n_cur; m_st = n_st; m_lat = n_lat; m_stall = n_stall;
      @(negedge clk);
   endtask

   task automatic burst(logic [AW-1:0] start, int len, string tag);
      step(1, 0, 0, 1, 0, 0, start, "R1");
      for (int i = 0; i < len; i++) step(1, 0, 0, 1, 0, 1, 24'h5A5A5A, tag);
   endtask

   initial begin
      m_cur = '0; m_st = 0; m_stall = 0; m_lat = 0;
      cfg_latency = 3'd4; cfg_wait_early = 0; cfg_wait_pol = 0;
      rst_n = 0; ce_n = 1; oe_n = 1; sync_mode = 0; wr_cycle = 0;
      addr_lock = 1; addr_in = '0;
      @(negedge clk);
      // R11: reset state
      for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, 1, 24'h123456, "R11");
      // R1 transparency, R2 hold, R3 clock ignored in async and write
      for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 0, 24'h000100 + 24'(i * 7), "R1");
      for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, 1, 24'hABCDE0 + 24'(i), "R2");
      step(1, 0, 1, 1, 1, 0, 24'h00F00D, "R1");
      for (int i = 0; i < 5; i++) step(1, 0, 1, 1, 1, 1, 24'h777000 + 24'(i), "R3");
      // R4 R5 R6 R8: latency 4, late wait, active low, crossing 0x10
      burst(24'h00000C, 12, "R5");
      // R6 R9 R10: latency 0 -> 2, early wait, active high
      cfg_latency = 3'd0; cfg_wait_early = 1; cfg_wait_pol = 1;
      burst(24'h00001E, 8, "R6");
      // R4: latency 7 with lock held low three edges (restart each edge)
      cfg_latency = 3'd7; cfg_wait_early = 0;
      step(1, 0, 0, 1, 0, 0, 24'h000200, "R4");
      step(1, 0, 0, 1, 0, 0, 24'h000201, "R4");
      burst(24'h00020E, 12, "R4");
      // R7: output enable and chip enable released mid-burst
      cfg_latency = 3'd2; cfg_wait_pol = 0; cfg_wait_early = 1;
      burst(24'hFFFFFD, 4, "R5");
      step(1, 0, 1, 1, 0, 1, 0, "R7");
      step(1, 1, 0, 1, 0, 1, 0, "R7");
      step(1, 0, 0, 1, 0, 1, 0, "R7");
      // R11: reset in mid burst
      burst(24'h000033, 3, "R5");
      step(0, 0, 0, 1, 0, 1, 0, "R11");
      step(1, 0, 0, 1, 0, 1, 0, "R11");
      // random phase: long locked stretches, flipping modes and config
      for (int i = 0; i < 3000; i++) begin
         bit lk = ($urandom_range(0, 9) != 0);
         if ($urandom_range(0, 63) == 0) begin
            cfg_latency = 3'($urandom_range(0, 7));
            cfg_wait_early = 1'($urandom_range(0, 1));
            cfg_wait_pol = 1'($urandom_range(0, 1));
         end
         step($urandom_range(0, 199) != 0, $urandom_range(0, 15) == 0,
              $urandom_range(0, 9) == 0, $urandom_range(0, 11) != 0,
              $urandom_range(0, 11) == 0, lk, 24'($urandom), lk ? "R2" : "R1");
      end
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule